// File: doc/BRIEF.md
# Single-Wire Pulse-Count Register Writer

This block turns activity on one write-only control wire into register writes for the rest of the chip. The wire idles high. A sender first transmits a register address as a burst of short low-going pulses, parks the wire high to close that burst, then transmits the data value the same way. The value of a burst is one less than the number of rising edges it contains, so one low pulse carries the value zero. The burst closes once the wire has stayed high for a minimum hold period. When a data burst closes, the block issues a one-cycle write strobe carrying the 5-bit address and the 6-bit data.

All durations are measured in ticks of a clock prescaler. Every threshold is a parameter counted in ticks, so the same logic runs with real microsecond timing or with scaled timing. Long levels on the wire carry meaning of their own:
- A long high enables the block.
- A very long low shuts it down and clears pending state, with a strobe to reset downstream registers.
- Holding high long enough after traffic flags standby.
- Overlong holds and overlong bursts re-align the address and data framing.

Top module: `pulse_reg_writer`

## Requirements
- R1: After reset, `chip_en_o`, `standby_o`, `wr_en_o` and `shutdown_o` are all low, and no write is issued while the block is disabled.
- R2: While disabled, the block enables (`chip_en_o` high) once the wire has been high for `STARTUP_T` ticks, and not before.
- R3: An address burst of n rising edges (1 ≤ n ≤ 32), closed by a high of at least `HOLD_MIN` ticks, selects address n−1. A following data burst of m rising edges (1 ≤ m ≤ 64), closed the same way, produces exactly one single-cycle `wr_en_o` pulse with `wr_addr_o` = n−1 and `wr_data_o` = m−1. No write occurs unless `chip_en_o` is high.
- R4: Bursts strictly alternate between address and data. A burst arriving right after a completed write is taken as an address.
- R5: If the high after an address burst reaches `HOLDA_MAX` ticks, the pending address is discarded and the next burst is taken as an address.
- R6: An address burst with more than 32 rising edges locks the receiver. No write is produced until the wire has stayed high for `BUS_RESET_T` ticks. After that the next burst is an address.
- R7: A data burst with more than 64 rising edges produces no write, and the next burst is taken as an address.
- R8: `standby_o` rises once the wire has been high for `STANDBY_T` ticks and falls on the next falling edge. Entering standby forces the next burst to be an address.
- R9: A low lasting `LOW_MAX` ticks aborts the burst in progress, including a pending address. Counting restarts from the next rising edge, and that burst is taken as an address.
- R10: A low lasting `SHUTDOWN_T` ticks while enabled drops `chip_en_o`, pulses `shutdown_o` for one cycle and discards any pending address. Re-enabling requires a new `STARTUP_T` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Asynchronous single-wire input, idles high |
| chip_en_o | output | 1 | Block enabled |
| standby_o | output | 1 | Wire idle high long enough for standby |
| shutdown_o | output | 1 | One-cycle strobe when the block disables itself |
| wr_en_o | output | 1 | One-cycle register write strobe |
| wr_addr_o | output | 5 | Register address of the write |
| wr_data_o | output | 6 | Data of the write |

## Verification
The bench sweeps every address and every data value with arithmetic expected values. It includes the edge counts 1, 32 and 64, where an off-by-one in the edge-to-value mapping would shift or wrap the result. It then sends a bare second data burst: a design that failed to alternate would write it to the old address instead of treating it as an address. Overlong address holds, oversized address and data bursts and an overlong low are each sent. A design that mishandled any of them would either write a stale pairing or stay out of step, writing data into the wrong register. Standby and shutdown are exercised to show that pending framing is cleared and the enable state is only regained after a fresh startup high.

// File: rtl/pulse_reg_writer.sv
module pulse_reg_writer #(
  parameter int TICK_DIV    = 50,
  parameter int LOW_MAX     = 251,
  parameter int HOLD_MIN    = 550,
  parameter int HOLDA_MAX   = 5000,
  parameter int STANDBY_T   = 10000,
  parameter int BUS_RESET_T = 12000,
  parameter int STARTUP_T   = 1000,
  parameter int SHUTDOWN_T  = 10000,
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_i,
  output logic              chip_en_o,
  output logic              standby_o,
  output logic              shutdown_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);

  function automatic int maxi(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int ADDR_EDGES = 1 << ADDR_W;
  localparam int DATA_EDGES = 1 << DATA_W;
  localparam int CNT_W      = DATA_W + 2;
  localparam int DUR_CAP    = maxi(maxi(maxi(BUS_RESET_T, STANDBY_T), maxi(SHUTDOWN_T, HOLDA_MAX)),
                                   maxi(maxi(STARTUP_T, HOLD_MIN), LOW_MAX));
  localparam int DUR_W      = $clog2(DUR_CAP + 1);
  localparam int PRE_W      = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  localparam logic [PRE_W-1:0] PRE_LAST  = PRE_W'(TICK_DIV - 1);
  localparam logic [DUR_W-1:0] D_CAP     = DUR_W'(DUR_CAP);
  localparam logic [DUR_W-1:0] D_LOW     = DUR_W'(LOW_MAX - 1);
  localparam logic [DUR_W-1:0] D_HOLD    = DUR_W'(HOLD_MIN - 1);
  localparam logic [DUR_W-1:0] D_HOLDA   = DUR_W'(HOLDA_MAX - 1);
  localparam logic [DUR_W-1:0] D_STBY    = DUR_W'(STANDBY_T - 1);
  localparam logic [DUR_W-1:0] D_BRST    = DUR_W'(BUS_RESET_T - 1);
  localparam logic [DUR_W-1:0] D_START   = DUR_W'(STARTUP_T - 1);
  localparam logic [DUR_W-1:0] D_SHUT    = DUR_W'(SHUTDOWN_T - 1);
  localparam logic [CNT_W-1:0] CNT_TOP   = '1;
  localparam logic [CNT_W-1:0] ADDR_LIM  = CNT_W'(ADDR_EDGES);
  localparam logic [CNT_W-1:0] DATA_LIM  = CNT_W'(DATA_EDGES);

  logic [1:0]        sync;
  logic              s, s_d, chg, tick, step;
  logic [PRE_W-1:0]  pre;
  logic [DUR_W-1:0]  dur;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] addr_q;
  logic              data_ph, locked;

  assign s    = sync[1];
  assign chg  = s ^ s_d;
  assign tick = (pre == PRE_LAST);
  assign step = tick & ~chg & (dur != D_CAP);

  logic at_low, at_hold, at_holda, at_stby, at_brst, at_start, at_shut;
  assign at_low   = step & ~s & (dur == D_LOW);
  assign at_shut  = step & ~s & (dur == D_SHUT);
  assign at_hold  = step &  s & (dur == D_HOLD);
  assign at_holda = step &  s & (dur == D_HOLDA);
  assign at_stby  = step &  s & (dur == D_STBY);
  assign at_brst  = step &  s & (dur == D_BRST);
  assign at_start = step &  s & (dur == D_START);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync <= '0;
      s_d  <= 1'b0;
      pre  <= '0;
      dur  <= '0;
    end else begin
      sync <= {sync[0], line_i};
      s_d  <= s;
      pre  <= (chg || tick) ? '0 : pre + 1'b1;
      if (chg)       dur <= '0;
      else if (step) dur <= dur + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chip_en_o  <= 1'b0;
      standby_o  <= 1'b0;
      shutdown_o <= 1'b0;
      wr_en_o    <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
      cnt        <= '0;
      addr_q     <= '0;
      data_ph    <= 1'b0;
      locked     <= 1'b0;
    end else begin
      wr_en_o    <= 1'b0;
      shutdown_o <= 1'b0;
      if (!chip_en_o) begin
        cnt       <= '0;
        data_ph   <= 1'b0;
        locked    <= 1'b0;
        standby_o <= 1'b0;
        if (at_start) chip_en_o <= 1'b1;
      end else if (at_shut) begin
        chip_en_o  <= 1'b0;
        shutdown_o <= 1'b1;
        standby_o  <= 1'b0;
        cnt        <= '0;
        addr_q     <= '0;
        data_ph    <= 1'b0;
        locked     <= 1'b0;
      end else begin
        if (chg && !s) standby_o <= 1'b0;
        if (chg && s && !locked && cnt != CNT_TOP) cnt <= cnt + 1'b1;
        if (at_low) begin
          cnt     <= '0;
          data_ph <= 1'b0;
        end
        if (at_hold && cnt != '0) begin
          cnt <= '0;
          if (!data_ph) begin
            if (cnt > ADDR_LIM) locked <= 1'b1;
            else begin
              addr_q  <= ADDR_W'(cnt - 1'b1);
              data_ph <= 1'b1;
            end
          end else begin
            data_ph <= 1'b0;
            if (cnt <= DATA_LIM) begin
              wr_en_o   <= 1'b1;
              wr_addr_o <= addr_q;
              wr_data_o <= DATA_W'(cnt - 1'b1);
            end
          end
        end
        if (at_holda && data_ph && cnt == '0) data_ph <= 1'b0;
        if (at_stby) begin
          standby_o <= 1'b1;
          data_ph   <= 1'b0;
        end
        if (at_brst) begin
          locked  <= 1'b0;
          data_ph <= 1'b0;
        end
      end
    end
  end

  p_no_write_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> chip_en_o);

  p_enable_on_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chip_en_o) |-> s);

  p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> !wr_en_o);

  p_locked_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !data_ph);

  p_standby_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    standby_o |-> s_d);

  p_shutdown_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chip_en_o) |-> shutdown_o);

  p_shutdown_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_o |=> !shutdown_o && !chip_en_o);

endmodule

// File: tb/test_pulse_reg_writer.sv
module test_pulse_reg_writer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line = 1'b0;
  logic chip_en, standby, shutdown, wr_en;
  logic [4:0] wr_addr;
  logic [5:0] wr_data;

  always #10 clk = ~clk;

  pulse_reg_writer #(
    .TICK_DIV(2), .LOW_MAX(6), .HOLD_MIN(10), .HOLDA_MAX(30), .STANDBY_T(60),
    .BUS_RESET_T(80), .STARTUP_T(8), .SHUTDOWN_T(50), .ADDR_W(5), .DATA_W(6)
  ) i_pulse_reg_writer (
    .clk(clk), .rst_n(rst_n), .line_i(line), .chip_en_o(chip_en),
    .standby_o(standby), .shutdown_o(shutdown), .wr_en_o(wr_en),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  int total = 0, bad = 0;
  int wcount = 0, scount = 0, multi = 0;
  int last_a = -1, last_d = -1;
  bit prev_wr = 1'b0, done = 1'b0;

  always @(negedge clk) begin
    if (wr_en) begin
      wcount++;
      last_a = int'(wr_addr);
      last_d = int'(wr_data);
      if (prev_wr) multi++;
    end
    if (shutdown) scount++;
    prev_wr = wr_en;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic burst(input int edges, input int hold);
    for (int i = 0; i < edges; i++) begin
      line = 1'b0; idle(2);
      line = 1'b1; idle(2);
    end
    idle(hold);
  endtask

  task automatic pair(input int a, input int d);
    burst(a + 1, 24);
    burst(d + 1, 24);
  endtask

  task automatic expect_write(input string req, input int w0, input int a, input int d);
    check(wcount == w0 + 1, {req, " write count"}, wcount - w0, 1);
    check(last_a == a, {req, " address"}, last_a, a);
    check(last_d == d, {req, " data"}, last_d, d);
  endtask

  initial begin
    int w0;
    idle(5);
    rst_n = 1'b1;
    idle(4);
    check(!chip_en && !standby, "R1 outputs idle after reset", {30'd0, chip_en, standby}, 0);
    check(wcount == 0 && scount == 0, "R1 no strobes", wcount + scount, 0);

    line = 1'b1;
    idle(10);
    check(!chip_en, "R2 not yet enabled", chip_en, 0);
    idle(30);
    check(chip_en, "R2 enabled after startup high", chip_en, 1);

    for (int a = 0; a < 32; a++) begin
      w0 = wcount;
      pair(a, (a * 13 + 5) % 64);
      expect_write("R3 address sweep", w0, a, (a * 13 + 5) % 64);
    end
    for (int d = 0; d < 64; d++) begin
      w0 = wcount;
      pair((d * 7) % 32, d);
      expect_write("R3 data sweep", w0, (d * 7) % 32, d);
    end
    check(multi == 0, "R3 strobe one cycle", multi, 0);

    w0 = wcount;
    pair(4, 9);
    burst(12, 24);
    check(wcount == w0 + 1, "R4 bare burst not written", wcount - w0, 1);
    burst(21, 24);
    check(wcount == w0 + 2, "R4 pairing restarts", wcount - w0, 2);
    check(last_a == 11 && last_d == 20, "R4 new pair values", last_a * 64 + last_d, 11 * 64 + 20);

    w0 = wcount;
    burst(6, 70);
    burst(9, 24);
    check(wcount == w0, "R5 long address hold drops address", wcount - w0, 0);
    burst(4, 24);
    expect_write("R5 after bus reset", w0, 8, 3);

    w0 = wcount;
    burst(40, 24);
    burst(3, 24);
    burst(3, 24);
    burst(3, 24);
    check(wcount == w0, "R6 locked after address overflow", wcount - w0, 0);
    idle(180);
    pair(2, 5);
    expect_write("R6 recovered after bus reset", w0, 2, 5);

    w0 = wcount;
    burst(4, 24);
    burst(70, 24);
    check(wcount == w0, "R7 data overflow dropped", wcount - w0, 0);
    pair(5, 1);
    expect_write("R7 next burst is address", w0, 5, 1);

    idle(60);
    check(!standby, "R8 standby not early", standby, 0);
    idle(60);
    check(standby, "R8 standby after long high", standby, 1);
    w0 = wcount;
    burst(1, 0);
    idle(2);
    check(!standby, "R8 standby cleared by low", standby, 0);
    idle(22);
    burst(10, 24);
    expect_write("R8 standby forces address", w0, 0, 9);

    w0 = wcount;
    burst(8, 24);
    burst(2, 0);
    line = 1'b0; idle(16);
    line = 1'b1; idle(24);
    check(wcount == w0, "R9 long low aborts data", wcount - w0, 0);
    burst(3, 24);
    expect_write("R9 restart as address", w0, 0, 2);

    w0 = wcount;
    burst(4, 24);
    line = 1'b0; idle(120);
    check(!chip_en, "R10 disabled by long low", chip_en, 1'b0);
    check(scount == 1, "R10 shutdown strobe", scount, 1);
    line = 1'b1; idle(6);
    check(!chip_en, "R10 needs fresh startup", chip_en, 0);
    idle(34);
    check(chip_en, "R10 re-enabled", chip_en, 1);
    burst(6, 24);
    burst(3, 24);
    expect_write("R10 pending address lost", w0, 5, 2);
    check(multi == 0, "R3 strobe one cycle at end", multi, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule